// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor With End-Around Carry

This block adds or subtracts two signed integers held in ones-complement form. The width is a parameter and defaults to 4 bits. A single select line chooses the operation. In subtract mode every bit of the second operand is inverted, which is its ones-complement negation, and the inverted value is then added.

The block sums the two effective operands in a ripple adder. The carry out of the top position is not discarded. It goes to the carry input of a second ripple pass that adds it into the raw sum. The output of that second pass is the result. It is passed out unchanged, so a zero result may appear as either all zeros or all ones. Two flags come with the result. One marks a signed overflow. The other marks a result that is either form of zero.

The block is purely combinational. It has no clock and no storage.

Top module: `oc_addsub`

## Requirements
- R1: With `sub_sel` = 0 and no overflow, `sum_out` decodes to the ones-complement value of `a_in` plus that of `b_in`. Decoding works as follows: MSB 0 means the value is the bits themselves, and MSB 1 means the value is minus the bit-inverse.
- R2: With `sub_sel` = 1, the effective second operand is `b_in` with every bit inverted. Without overflow, `sum_out` decodes to value(`a_in`) minus value(`b_in`).
- R3: `ovf_out` is 1 exactly when both effective operands have the same MSB and `sum_out` has the other MSB. This is the case when the true result lies outside ±(2^(W−1)−1).
- R4: When the raw W-bit sum carries out of its MSB, `sum_out` equals the raw low W bits plus one. Two examples: 0101+1101 gives 0011, and 1010+1101 gives 1000.
- R5: `zero_out` is 1 exactly when `sum_out` is all zeros or all ones.
- R6: Both zero encodings, 0000 and 1111, are accepted as operands. Adding either one to an operand x yields a result that decodes to the value of x.
- R7: A zero result is not normalised. For example, 0011+1100 yields 1111.
- R8: The second pass, which adds the fed-back carry, never carries out of the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand, ones-complement |
| b_in | input | W | Second operand, ones-complement |
| sub_sel | input | 1 | 1 selects a_in minus b_in, 0 selects addition |
| sum_out | output | W | Corrected result after the end-around carry |
| ovf_out | output | 1 | Signed overflow of the result |
| zero_out | output | 1 | Result is either encoding of zero |

## Verification
The bench sweeps every operand pair at width 4 in both modes. For each pair it checks the result bits and, where the value is in range, the decoded value. Both are compared against an integer model that decodes ones-complement values and folds the carry back arithmetically. Overflow and zero flags are checked on every pair. The sweep therefore covers operands of mixed and equal sign, and it separates pairs that need the end-around increment from pairs that do not. Directed cases cover the two worked examples, operands of either zero encoding, and a zero result left as all ones. Together they tell a dropped carry feedback apart from a wrong inversion or a normalised zero.

// File: rtl/oc_pkg.sv
package oc_pkg;

    // Flags produced by the result checker
    typedef struct packed {
        logic ovf;
        logic zero;
    } oc_flags_t;

endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
    parameter int W = 4
) (
    input  logic [W-1:0] b_raw,
    input  logic         sub_sel,
    output logic [W-1:0] b_eff
);

    typedef struct packed {
        logic [W-1:0] b_eff;
    } prep_t;

    prep_t prep_d;

    // Ones-complement negation is a plain bitwise inversion
    always_comb begin
        prep_d       = '0;
        prep_d.b_eff = b_raw ^ {W{sub_sel}};
    end

    assign b_eff = prep_d.b_eff;

endmodule

// File: rtl/oc_ripple.sv
module oc_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out
);

    logic [W:0] chain_d;

    assign chain_d[0] = c_in;

    // One full-adder cell per bit position
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_cell
            logic half_d;
            assign half_d         = x_in[g] ^ y_in[g];
            assign s_out[g]       = half_d ^ chain_d[g];
            assign chain_d[g + 1] = (x_in[g] & y_in[g]) | (chain_d[g] & half_d);
        end
    endgenerate

    assign c_out = chain_d[W];

endmodule

// File: rtl/oc_result_check.sv
module oc_result_check
    import oc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         a_sign,
    input  logic         b_sign,
    input  logic [W-1:0] result,
    output oc_flags_t    flags
);

    localparam int MSB = W - 1;

    typedef struct packed {
        oc_flags_t flags;
    } chk_t;

    chk_t chk_d;

    always_comb begin
        chk_d            = '0;
        // Same-sign operands whose result changes sign have overflowed
        chk_d.flags.ovf  = (a_sign == b_sign) && (result[MSB] != a_sign);
        // Both zero encodings are recognised; the result is not altered
        chk_d.flags.zero = (result == '0) || (result == '1);
    end

    assign flags = chk_d.flags;

endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
    import oc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sub_sel,
    output logic [W-1:0] sum_out,
    output logic         ovf_out,
    output logic         zero_out
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff_d;
    logic [W-1:0] raw_sum_d;
    logic         raw_cout_d;
    logic [W-1:0] fix_sum_d;
    logic         fix_cout_d;
    oc_flags_t    flags_d;

    oc_operand_prep #(.W(W)) u_prep (
        .b_raw   (b_in),
        .sub_sel (sub_sel),
        .b_eff   (b_eff_d)
    );

    // First pass: plain binary addition of the effective operands
    oc_ripple #(.W(W)) u_main (
        .x_in  (a_in),
        .y_in  (b_eff_d),
        .c_in  (1'b0),
        .s_out (raw_sum_d),
        .c_out (raw_cout_d)
    );

    // Second pass: carry out of the MSB re-enters at the LSB
    oc_ripple #(.W(W)) u_wrap (
        .x_in  (raw_sum_d),
        .y_in  ({W{1'b0}}),
        .c_in  (raw_cout_d),
        .s_out (fix_sum_d),
        .c_out (fix_cout_d)
    );

    oc_result_check #(.W(W)) u_chk (
        .a_sign (a_in[MSB]),
        .b_sign (b_eff_d[MSB]),
        .result (fix_sum_d),
        .flags  (flags_d)
    );

    assign sum_out  = fix_sum_d;
    assign ovf_out  = flags_d.ovf;
    assign zero_out = flags_d.zero;

    always_comb begin
        AST_WRAP_NO_CARRY: assert (!fix_cout_d);                                          // R8
        AST_SUB_INVERTS: assert (!sub_sel || (b_eff_d == ~b_in));                         // R2
        AST_ADD_PASSES: assert (sub_sel || (b_eff_d == b_in));                            // R1
        AST_NO_CARRY_NO_FIX: assert (raw_cout_d || (sum_out == raw_sum_d));               // R4
        AST_ZERO_NO_OVERFLOW: assert (!(zero_out && ovf_out));                            // R5
        AST_OVF_SAME_SIGN: assert (!ovf_out || (a_in[MSB] == b_eff_d[MSB]));              // R3
    end

endmodule

// File: tb/sim_oc_addsub.sv
module sim_oc_addsub;

    localparam int W = 4;
    localparam int M = (1 << W) - 1;
    localparam int LIM = (1 << (W - 1)) - 1;

    logic clk = 1'b0;
    logic [W-1:0] a_in, b_in, sum_out;
    logic sub_sel, ovf_out, zero_out;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    oc_addsub #(.W(W)) u0 (
        .a_in     (a_in),
        .b_in     (b_in),
        .sub_sel  (sub_sel),
        .sum_out  (sum_out),
        .ovf_out  (ovf_out),
        .zero_out (zero_out)
    );

    function automatic int decode(input int v);
        if (v & (1 << (W - 1))) return -((~v) & M);
        return v;
    endfunction

    function automatic int fold(input int a, input int b, input bit s);
        int t;
        t = a + (s ? ((~b) & M) : b);
        if (t > M) t = t - (M + 1) + 1;
        return t & M;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input bit s);
        @(posedge clk);
        a_in = a[W-1:0];
        b_in = b[W-1:0];
        sub_sel = s;
        @(negedge clk);
    endtask

    initial begin
        a_in = '0; b_in = '0; sub_sel = 1'b0;
        @(negedge clk);
        // initial state with zero inputs
        check(sum_out == 4'b0000, "R1 init", sum_out, 0);
        check(zero_out == 1'b1, "R5 init", zero_out, 1);

        // R4 worked examples
        apply(4'b0101, 4'b1101, 1'b0);
        check(sum_out == 4'b0011, "R4 ex1", sum_out, 3);
        apply(4'b1010, 4'b1101, 1'b0);
        check(sum_out == 4'b1000, "R4 ex2", sum_out, 8);
        // R7 zero kept as all ones
        apply(4'b0011, 4'b1100, 1'b0);
        check(sum_out == 4'b1111, "R7", sum_out, 15);
        check(zero_out == 1'b1, "R7 zero", zero_out, 1);

        // R6 both zero encodings as operands
        for (int x = 0; x <= M; x++) begin
            apply(x, 0, 1'b0);
            check(decode(int'(sum_out)) == decode(x), "R6 plus0", sum_out, x);
            apply(x, M, 1'b0);
            check(decode(int'(sum_out)) == decode(x), "R6 minus0", sum_out, x);
        end

        // Exhaustive sweep, both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a <= M; a++) begin
                for (int b = 0; b <= M; b++) begin
                    int ev, eb, ebits;
                    bit eo;
                    ev = decode(a) + (s ? -decode(b) : decode(b));
                    eo = (ev > LIM) || (ev < -LIM);
                    ebits = fold(a, b, s[0]);
                    apply(a, b, s[0]);
                    eb = int'(sum_out);
                    check(eb == ebits, s ? "R2 bits" : "R1 bits", eb, ebits);
                    if (!eo)
                        check(decode(eb) == ev, s ? "R2 value" : "R1 value", decode(eb), ev);
                    check(ovf_out == eo, "R3", ovf_out, eo);
                    check(zero_out == ((ebits == 0) || (ebits == M)), "R5", zero_out,
                          (ebits == 0) || (ebits == M));
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule